// File: doc/BRIEF.md
# Multi-Way Stream Prefetch Buffer

This block keeps prefetched cache lines in a few small FIFO stream buffers that sit beside a cache. Prefetched lines are never written straight into the cache. Each demand lookup is presented together with the cache's own hit result for the same line address. Only the head entry of each buffer is compared. A ready head that matches is handed to the lookup port in the same cycle and is promoted to the cache one cycle later. Leaving its buffer frees a slot, and that slot fetches the next line in sequence.

A lookup that misses the cache and matches no head starts a new stream. The least recently used buffer is cleared and begins fetching the lines that follow the missing address. A head that matches but is still waiting for its fill stalls the lookup. Line fills use a request/response port tagged with the buffer index. Each buffer has at most one request outstanding at a time. Several buffers let several independent streams be followed at once.

Top module: `stream_pf_buf`

## Requirements
- R1: While reset is held and directly after it, lk_hit_o, lk_stall_o, mem_req_valid_o and pr_valid_o are all 0.
- R2: A lookup with lk_valid_i=1, lk_cache_hit_i=0 and no matching head (ready or pending) allocates a buffer. That buffer then requests line addresses A+1, A+2, A+3, ... in order, where A is the lookup address. mem_req_id_o carries the buffer index.
- R3: A lookup with lk_cache_hit_i=1 leaves every buffer unchanged. It gives lk_hit_o=0, lk_stall_o=0, no allocation, no new request and no promotion.
- R4: Only the head entry of a buffer is compared. A lookup for a line held deeper in a buffer is treated as a double miss.
- R5: A lookup that matches a ready head gives lk_hit_o=1 and that line's data on lk_data_o in the same cycle, and removes the line from its buffer.
- R6: In the cycle after a buffer hit, pr_valid_o=1 and pr_addr_o/pr_data_o carry the hit line's address and data. Otherwise pr_valid_o=0.
- R7: A lookup that matches a head whose fill has not returned gives lk_stall_o=1 and lk_hit_o=0. It allocates nothing and removes nothing, and it hits once the fill has landed.
- R8: Each buffer has at most one fill request outstanding. A slot freed by a hit issues the next sequential line address.
- R9: The buffer allocated on a double miss is the least recently used one, where allocations and hits count as uses. After reset the order of use is 0 (newest) through NUM_BUF-1 (oldest), so buffer NUM_BUF-1 is taken first.
- R10: If a buffer is reallocated while a fill is in flight, that fill is discarded when it returns. The buffer issues no request until it has returned.
- R11: A buffer holds at most DEPTH lines. With no hits it stops requesting after DEPTH fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup present this cycle |
| lk_addr_i | input | ADDR_W | Lookup line address |
| lk_cache_hit_i | input | 1 | Cache hit result for the same lookup |
| lk_hit_o | output | 1 | Lookup hit a ready buffer head |
| lk_stall_o | output | 1 | Lookup matched a head still being filled |
| lk_data_o | output | DATA_W | Line data on a buffer hit |
| pr_valid_o | output | 1 | Promote line into the cache |
| pr_addr_o | output | ADDR_W | Promoted line address |
| pr_data_o | output | DATA_W | Promoted line data |
| mem_req_valid_o | output | 1 | Fill request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Requested line address |
| mem_req_id_o | output | $clog2(NUM_BUF) | Buffer issuing the request |
| mem_rsp_valid_i | input | 1 | Fill response valid |
| mem_rsp_id_i | input | $clog2(NUM_BUF) | Buffer the response belongs to |
| mem_rsp_data_i | input | DATA_W | Fill line data |

## Verification
Two functions can meet in one cycle. One is a double miss that reallocates a buffer. The other is that buffer's old fill being in flight, or landing. The bench holds all memory responses while it forces the victim of the recency order to be a buffer with a fill outstanding. It then checks that no request carrying that buffer index appears until the stale response is released. After release, the new stream's data must be correct and the old line must not hit. The same kind of overlap, a head leaving a buffer while that buffer's tail issues, is exercised by back-to-back hits while refills run. It is judged by the exact order of request addresses for that buffer index.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [1:0] {
    ENT_EMPTY = 2'd0,
    ENT_PEND  = 2'd1,
    ENT_READY = 2'd2
  } ent_state_e;
endpackage

// File: rtl/spb_fifo.sv
module spb_fifo
  import spb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              pop_i,
  input  logic              issue_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic              head_rdy_o,
  output logic              head_pnd_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              want_req_o,
  output logic [ADDR_W-1:0] req_addr_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ent_state_e        ent_st   [DEPTH];
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [PW-1:0]     hd, tl, pidx;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] nxt;
  logic              active, outst, discard;

  function automatic logic [PW-1:0] inc_p(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_addr_o = ent_addr[hd];
  assign head_data_o = ent_data[hd];
  assign head_rdy_o  = (ent_st[hd] == ENT_READY);
  assign head_pnd_o  = (ent_st[hd] == ENT_PEND);
  assign want_req_o  = active && !outst && (cnt < CW'(DEPTH)) && !alloc_i;
  assign req_addr_o  = nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_st[i]   <= ENT_EMPTY;
        ent_addr[i] <= '0;
        ent_data[i] <= '0;
      end
      hd      <= '0;
      tl      <= '0;
      pidx    <= '0;
      cnt     <= '0;
      nxt     <= '0;
      active  <= 1'b0;
      outst   <= 1'b0;
      discard <= 1'b0;
    end else if (alloc_i) begin
      for (int i = 0; i < DEPTH; i++) ent_st[i] <= ENT_EMPTY;
      hd      <= '0;
      tl      <= '0;
      cnt     <= '0;
      nxt     <= alloc_addr_i;
      active  <= 1'b1;
      // a fill still in flight belongs to the old stream
      outst   <= outst && !fill_i;
      discard <= outst && !fill_i;
    end else begin
      if (issue_i) begin
        ent_st[tl]   <= ENT_PEND;
        ent_addr[tl] <= nxt;
        pidx         <= tl;
        tl           <= inc_p(tl);
        nxt          <= nxt + 1'b1;
        outst        <= 1'b1;
      end
      if (fill_i) begin
        outst <= 1'b0;
        if (discard) begin
          discard <= 1'b0;
        end else begin
          ent_st[pidx]   <= ENT_READY;
          ent_data[pidx] <= fill_data_i;
        end
      end
      if (pop_i) begin
        ent_st[hd] <= ENT_EMPTY;
        hd         <= inc_p(hd);
      end
      cnt <= cnt + CW'(issue_i) - CW'(pop_i);
    end
  end

  a_r8_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !outst);
  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (cnt < CW'(DEPTH)));
  a_r5_pop_ready_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_rdy_o);
  a_r10_discard_inflight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard |-> outst);
endmodule

// File: rtl/spb_lru.sv
module spb_lru #(
  parameter int NUM = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   touch_i,
  input  logic [$clog2(NUM)-1:0] touch_idx_i,
  output logic [$clog2(NUM)-1:0] victim_o
);
  localparam int IW = $clog2(NUM);

  logic [IW-1:0] age [NUM];
  logic [NUM-1:0] old_vec;

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < NUM; i++) begin
      old_vec[i] = (age[i] == IW'(NUM - 1));
      if (old_vec[i]) victim_o = IW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM; i++) age[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < NUM; i++) begin
        if (IW'(i) == touch_idx_i)         age[i] <= '0;
        else if (age[i] < age[touch_idx_i]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  a_r9_single_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(old_vec));
endmodule

// File: rtl/spb_req_arb.sv
module spb_req_arb #(
  parameter int NUM = 4
) (
  input  logic [NUM-1:0]         want_i,
  output logic [NUM-1:0]         gnt_o,
  output logic [$clog2(NUM)-1:0] gnt_idx_o,
  output logic                   any_o
);
  localparam int IW = $clog2(NUM);

  // fixed priority, lowest index first
  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (want_i[i]) begin
        gnt_o     = '0;
        gnt_o[i]  = 1'b1;
        gnt_idx_o = IW'(i);
      end
    end
  end

  assign any_o = |want_i;
endmodule

// File: rtl/stream_pf_buf.sv
module stream_pf_buf #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lk_valid_i,
  input  logic [ADDR_W-1:0]          lk_addr_i,
  input  logic                       lk_cache_hit_i,
  output logic                       lk_hit_o,
  output logic                       lk_stall_o,
  output logic [DATA_W-1:0]          lk_data_o,
  output logic                       pr_valid_o,
  output logic [ADDR_W-1:0]          pr_addr_o,
  output logic [DATA_W-1:0]          pr_data_o,
  output logic                       mem_req_valid_o,
  input  logic                       mem_req_ready_i,
  output logic [ADDR_W-1:0]          mem_req_addr_o,
  output logic [$clog2(NUM_BUF)-1:0] mem_req_id_o,
  input  logic                       mem_rsp_valid_i,
  input  logic [$clog2(NUM_BUF)-1:0] mem_rsp_id_i,
  input  logic [DATA_W-1:0]          mem_rsp_data_i
);
  localparam int IW = $clog2(NUM_BUF);

  logic [ADDR_W-1:0]  head_addr [NUM_BUF];
  logic [DATA_W-1:0]  head_data [NUM_BUF];
  logic [ADDR_W-1:0]  req_addr  [NUM_BUF];
  logic [NUM_BUF-1:0] head_rdy, head_pnd, want, gnt;
  logic [NUM_BUF-1:0] m_rdy, m_pnd, alloc_vec, pop_vec, issue_vec, fill_vec;
  logic [IW-1:0]      hit_idx, victim, gnt_idx;
  logic               probe, dbl_miss;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    assign m_rdy[g]     = head_rdy[g] && (head_addr[g] == lk_addr_i);
    assign m_pnd[g]     = head_pnd[g] && (head_addr[g] == lk_addr_i);
    assign alloc_vec[g] = dbl_miss && (victim == IW'(g));
    assign pop_vec[g]   = lk_hit_o && (hit_idx == IW'(g));
    assign issue_vec[g] = gnt[g] && mem_req_ready_i;
    assign fill_vec[g]  = mem_rsp_valid_i && (mem_rsp_id_i == IW'(g));

    spb_fifo #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .DEPTH (DEPTH)
    ) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_vec[g]),
      .alloc_addr_i(lk_addr_i + 1'b1),
      .pop_i       (pop_vec[g]),
      .issue_i     (issue_vec[g]),
      .fill_i      (fill_vec[g]),
      .fill_data_i (mem_rsp_data_i),
      .head_addr_o (head_addr[g]),
      .head_rdy_o  (head_rdy[g]),
      .head_pnd_o  (head_pnd[g]),
      .head_data_o (head_data[g]),
      .want_req_o  (want[g]),
      .req_addr_o  (req_addr[g])
    );
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--)
      if (m_rdy[i]) hit_idx = IW'(i);
  end

  assign probe      = lk_valid_i && !lk_cache_hit_i;
  assign lk_hit_o   = probe && |m_rdy;
  assign lk_stall_o = probe && !(|m_rdy) && |m_pnd;
  assign dbl_miss   = probe && !(|m_rdy) && !(|m_pnd);
  assign lk_data_o  = head_data[hit_idx];

  spb_lru #(.NUM(NUM_BUF)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (dbl_miss || lk_hit_o),
    .touch_idx_i(dbl_miss ? victim : hit_idx),
    .victim_o   (victim)
  );

  spb_req_arb #(.NUM(NUM_BUF)) u_arb (
    .want_i   (want),
    .gnt_o    (gnt),
    .gnt_idx_o(gnt_idx),
    .any_o    (mem_req_valid_o)
  );

  assign mem_req_id_o   = gnt_idx;
  assign mem_req_addr_o = req_addr[gnt_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_valid_o <= 1'b0;
      pr_addr_o  <= '0;
      pr_data_o  <= '0;
    end else begin
      pr_valid_o <= lk_hit_o;
      if (lk_hit_o) begin
        pr_addr_o <= lk_addr_i;
        pr_data_o <= lk_data_o;
      end
    end
  end

  a_r6_promote_follows_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |=> (pr_valid_o && pr_addr_o == $past(lk_addr_i)));
  a_r3_cache_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_cache_hit_i) |-> (!lk_hit_o && !lk_stall_o && alloc_vec == '0));
  a_r7_stall_holds_buffers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_stall_o |-> (alloc_vec == '0 && pop_vec == '0));
  a_r2_single_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc_vec));
endmodule

// File: tb/stream_pf_buf_test.sv
module stream_pf_buf_test;
  localparam int NB = 4;
  localparam int DP = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0, lk_chit = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit, lk_stall, pr_valid, req_valid, rsp_valid = 1'b0;
  logic [DW-1:0] lk_data, pr_data, rsp_data = '0;
  logic [AW-1:0] pr_addr, req_addr;
  logic [IW-1:0] req_id, rsp_id = '0;

  always #4 clk = ~clk;

  stream_pf_buf #(.NUM_BUF(NB), .DEPTH(DP), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_cache_hit_i(lk_chit),
    .lk_hit_o(lk_hit), .lk_stall_o(lk_stall), .lk_data_o(lk_data),
    .pr_valid_o(pr_valid), .pr_addr_o(pr_addr), .pr_data_o(pr_data),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(1'b1),
    .mem_req_addr_o(req_addr), .mem_req_id_o(req_id),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_id_i(rsp_id), .mem_rsp_data_i(rsp_data)
  );

  int n_chk = 0, n_fail = 0;

  function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // memory model
  logic [AW-1:0] pa [NB];
  bit            pv [NB];
  int            pt [NB];
  int            lat = 2;
  bit            hold = 0;
  int            viol = 0;
  int            nlog = 0;
  logic [AW-1:0] log_addr [512];
  int            log_id   [512];

  initial for (int i = 0; i < NB; i++) begin pv[i] = 0; pt[i] = 0; pa[i] = '0; end

  always @(posedge clk) begin
    if (rsp_valid) pv[rsp_id] = 0;
    if (rst_n && req_valid) begin
      if (pv[req_id]) viol++;
      pv[req_id] = 1;
      pa[req_id] = req_addr;
      pt[req_id] = lat;
      if (nlog < 512) begin
        log_addr[nlog] = req_addr;
        log_id[nlog]   = int'(req_id);
        nlog++;
      end
    end
  end

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    for (int i = 0; i < NB; i++) if (pv[i] && pt[i] > 0) pt[i]--;
    if (!hold) begin
      for (int i = NB - 1; i >= 0; i--) begin
        if (pv[i] && pt[i] == 0) begin
          rsp_valid = 1'b1;
          rsp_id    = IW'(i);
          rsp_data  = line_of(pa[i]);
        end
      end
    end
  end

  // recency model: age 0 newest
  int bage [NB];
  initial for (int i = 0; i < NB; i++) bage[i] = i;

  task automatic touch(input int b);
    int a0 = bage[b];
    for (int i = 0; i < NB; i++) if (bage[i] < a0) bage[i]++;
    bage[b] = 0;
  endtask

  function automatic int model_victim();
    for (int i = 0; i < NB; i++) if (bage[i] == NB - 1) return i;
    return 0;
  endfunction

  logic          r_hit, r_stall;
  logic [DW-1:0] r_data;

  task automatic look(input logic [AW-1:0] a, input logic ch);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_chit = ch;
    #1;
    r_hit = lk_hit; r_stall = lk_stall; r_data = lk_data;
    @(posedge clk);
    #1;
    lk_valid = 1'b0; lk_chit = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int find_req(input int from, input logic [AW-1:0] a);
    for (int i = from; i < nlog; i++) if (log_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic dbl_miss(input logic [AW-1:0] a, output int vic);
    int mark = nlog;
    int idx = -1;
    vic = model_victim();
    look(a, 1'b0);
    chk(!r_hit && !r_stall, "R2 double miss no hit/stall", {r_hit, r_stall}, 0);
    for (int k = 0; k < 10 && idx < 0; k++) begin
      idx = find_req(mark, a + 1'b1);
      if (idx < 0) idx_wait();
    end
    chk(idx >= 0, "R2 first request A+1", idx, 0);
    if (idx >= 0) chk(log_id[idx] == vic, "R9 victim is LRU", log_id[idx], vic);
    touch(vic);
  endtask

  task automatic idx_wait();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(!lk_hit && !lk_stall && !req_valid && !pr_valid, "R1 in reset",
        {lk_hit, lk_stall, req_valid, pr_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk(!lk_hit && !lk_stall && !req_valid && !pr_valid, "R1 after reset",
        {lk_hit, lk_stall, req_valid, pr_valid}, 0);
  endtask

  task automatic t_stream();
    int mark = nlog;
    int cnt = 0;
    int v;
    dbl_miss(16'd100, v);
    chk(v == NB - 1, "R9 first victim is last buffer", v, NB - 1);
    idle(40);
    for (int i = mark; i < nlog; i++) begin
      if (log_id[i] == v) begin
        chk(log_addr[i] == 16'(101 + cnt), "R2 sequential fetch", log_addr[i], 101 + cnt);
        cnt++;
      end
    end
    chk(cnt == DP, "R11 stops at depth", cnt, DP);
    look(16'd101, 1'b0);
    chk(r_hit && r_data == line_of(16'd101), "R5 hit data", r_data, line_of(16'd101));
    chk(pr_valid && pr_addr == 16'd101 && pr_data == line_of(16'd101), "R6 promote",
        {pr_valid, pr_addr}, {1'b1, 16'd101});
    touch(v);
    look(16'd102, 1'b0);
    chk(r_hit && r_data == line_of(16'd102), "R5 head advanced", r_data, line_of(16'd102));
    touch(v);
    idle(30);
    cnt = 0;
    for (int i = mark; i < nlog; i++) if (log_id[i] == v) cnt++;
    chk(cnt == DP + 2, "R8 freed slots refetch", cnt, DP + 2);
    chk(log_id[nlog-1] == v && log_addr[nlog-1] == 16'd106, "R8 next sequential",
        log_addr[nlog-1], 106);
    chk(viol == 0, "R8 one outstanding", viol, 0);
  endtask

  task automatic t_cache_hit();
    int mark = nlog;
    look(16'd103, 1'b1);
    chk(!r_hit && !r_stall, "R3 cache hit ignores buffers", {r_hit, r_stall}, 0);
    chk(!pr_valid, "R3 no promote on cache hit", pr_valid, 0);
    idle(5);
    chk(nlog == mark, "R3 no allocation", nlog - mark, 0);
    look(16'd103, 1'b0);
    chk(r_hit && r_data == line_of(16'd103), "R3 line still held", r_data, line_of(16'd103));
    touch(NB - 1);
    idle(20);
  endtask

  task automatic t_head_only();
    int v;
    dbl_miss(16'd105, v);
    chk(v != NB - 1, "R4 deep entry not matched", v, 0);
    idle(20);
  endtask

  task automatic t_lru();
    int b1, b2, b3;
    dbl_miss(16'd1000, b1);
    dbl_miss(16'd2000, b2);
    idle(15);
    look(16'd1001, 1'b0);
    chk(r_hit && r_data == line_of(16'd1001), "R5 hit other stream", r_data, line_of(16'd1001));
    touch(b1);
    idle(10);
    dbl_miss(16'd9000, b3);
    chk(b3 != b1 && b3 != b2, "R9 recent buffers kept", b3, 0);
    idle(20);
  endtask

  task automatic t_stall();
    int v;
    lat = 20;
    dbl_miss(16'd3000, v);
    look(16'd3001, 1'b0);
    chk(r_stall && !r_hit, "R7 pending head stalls", {r_stall, r_hit}, 2'b10);
    chk(!pr_valid, "R7 no promote on stall", pr_valid, 0);
    idle(30);
    look(16'd3001, 1'b0);
    chk(r_hit && r_data == line_of(16'd3001), "R7 hit after fill", r_data, line_of(16'd3001));
    touch(v);
    lat = 2;
    idle(30);
  endtask

  task automatic t_discard();
    int x, o, mark, cnt, idx;
    idle(30);
    hold = 1;
    dbl_miss(16'd4000, x);
    dbl_miss(16'd5000, o);
    dbl_miss(16'd6000, o);
    dbl_miss(16'd7000, o);
    chk(model_victim() == x, "R10 setup victim", model_victim(), x);
    mark = nlog;
    look(16'd8000, 1'b0);
    chk(!r_hit && !r_stall, "R10 realloc miss", {r_hit, r_stall}, 0);
    touch(x);
    idle(10);
    cnt = 0;
    for (int i = mark; i < nlog; i++) if (log_id[i] == x) cnt++;
    chk(cnt == 0, "R10 no request while stale fill out", cnt, 0);
    hold = 0;
    idle(40);
    idx = find_req(mark, 16'd8001);
    chk(idx >= 0 && log_id[idx] == x, "R10 new stream after stale fill", idx, x);
    look(16'd8001, 1'b0);
    chk(r_hit && r_data == line_of(16'd8001), "R10 new data", r_data, line_of(16'd8001));
    look(16'd4001, 1'b0);
    chk(!r_hit, "R10 stale line dropped", r_hit, 0);
    chk(viol == 0, "R8 one outstanding overall", viol, 0);
  endtask

  bit done = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    idle(4);
    t_reset();
    t_stream();
    t_cache_hit();
    t_head_only();
    t_lru();
    t_stall();
    t_discard();
    idle(5);
    finish_run();
  end
endmodule